// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches a small number of page-table entries so that most memory accesses translate without walking the page table. A lookup presents a virtual page number, an address-space tag and an access kind (read, write or execute) together with the page offset. In the same cycle, and without a clock edge, the block answers with a hit and the physical address, a miss, or a protection fault. Every slot is compared at once, so any page may sit in any slot. The page offset passes through unchanged, because virtual and physical pages have the same size.

After a miss, the page-table walker installs the translation through the fill port. The slot it replaces is chosen in this order: a slot that already holds the same page and tag, then the lowest free slot, then a slot picked by a free-running pseudo-random generator. The block keeps a referenced flag and a modified flag for each slot. When a fill displaces a live slot whose flags are not both clear, the evict port reports that slot's page, tag and flags in the same cycle, so the page table can be brought up to date. Two flush inputs drop every translation, or only those of one address space, in a single cycle.

Top module: `tlb_assoc`

## Requirements
- R1: After reset no slot is live: every lookup reports a miss and the evict port stays idle.
- R2: A lookup whose page number and address-space tag equal those of a live slot that permits the access reports a hit, and the physical address equals the slot's physical page concatenated with the lookup offset. This happens in the same cycle. Access encoding: 0 = read, 1 = write, 2 = execute, 3 = nothing permitted.
- R3: A lookup that matches no live slot on both page number and tag reports a miss. A slot with the same page number but another tag does not match.
- R4: A lookup that matches a slot whose permission bit for the access is clear reports a fault and no hit. Permission field: bit 0 read, bit 1 write, bit 2 execute.
- R5: A fill goes into a free slot while one exists. No live translation is lost, and the evict port stays idle. A freshly installed slot has both flags clear.
- R6: A fill into a full buffer of a page not present displaces exactly one live slot, chosen pseudo-randomly.
- R7: A hit sets the slot's referenced flag. A write hit also sets its modified flag. A faulting lookup sets neither.
- R8: The evict port is valid only in a fill cycle that displaces a live slot with a flag set. It carries that slot's page number, tag and both flags.
- R9: A fill of a page and tag that are already present overwrites that slot, so no duplicate arises, and the old slot is reported under R8.
- R10: A global flush makes every slot free at the next clock edge.
- R11: A tagged flush frees only the slots carrying the given tag. All other slots keep translating.
- R12: A fill in the same cycle as any flush is dropped. Nothing is installed and nothing is reported.
- R13: When a lookup hits the slot that a same-cycle fill displaces, the eviction report includes the flags that this hit sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lk_off | input | OFF_W | Page offset, passed through |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching live slot |
| lk_fault | output | 1 | Matching slot forbids the access |
| lk_pa | output | PPN_W+OFF_W | Physical address on a hit, zero otherwise |
| fill_valid | input | 1 | Install request |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Tag to install |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_perm | input | 3 | Permissions to install (bit 0 R, 1 W, 2 X) |
| wb_valid | output | 1 | Eviction report valid |
| wb_vpn | output | VPN_W | Displaced page number |
| wb_asid | output | ASID_W | Displaced tag |
| wb_ref | output | 1 | Displaced referenced flag |
| wb_dirty | output | 1 | Displaced modified flag |
| flush_all | input | 1 | Free every slot |
| flush_asid_en | input | 1 | Free slots with tag flush_asid |
| flush_asid | input | ASID_W | Tag selected for the tagged flush |

## Verification
Two functions can coincide in one cycle. The first pair is a lookup hit and a fill that displaces the very slot being hit. The bench provokes it by refilling a page while a write lookup to the same page is presented, and it expects a hit on the old translation and an eviction report carrying both flags, although the slot was clean before that cycle. The second pair is a fill and a flush in the same cycle. The bench judges this from an idle evict port and from a later miss on the page that was offered. Random victims are not predicted. Instead, after each such fill the bench probes every earlier translation, requires exactly one to be gone, and compares the report against the flags its model holds for that page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

  function automatic logic perm_allows(logic [PERM_W-1:0] perm, logic [1:0] acc);
    logic ok;
    case (acc)
      ACC_READ:  ok = perm[PERM_RD];
      ACC_WRITE: ok = perm[PERM_WR];
      ACC_EXEC:  ok = perm[PERM_EX];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);

  logic [W-1:0] st_q;
  logic [W-1:0] st_n;
  logic         fb;

  always_comb begin
    fb   = ^(st_q & TAPS);
    st_n = {st_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= {{(W-1){1'b0}}, 1'b1};
    else if (step) st_q <= st_n;
  end

  assign state = st_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0); // R6

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     same_vec,
  input  logic [IDX_W-1:0] rnd,
  output logic [IDX_W-1:0] vidx
);

  always_comb begin
    vidx = rnd;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) vidx = IDX_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (same_vec[i]) vidx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int PPN_W  = 8,
  parameter int ASID_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid,
  input  logic              load,
  input  logic [VPN_W-1:0]  ld_vpn,
  input  logic [ASID_W-1:0] ld_asid,
  input  logic [PPN_W-1:0]  ld_ppn,
  input  logic [PERM_W-1:0] ld_perm,
  input  logic              touch,
  input  logic              touch_wr,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              valid,
  output logic              refb,
  output logic              dirty,
  output logic [VPN_W-1:0]  vpn,
  output logic [ASID_W-1:0] asid,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm,
  output logic              lk_match,
  output logic              ld_match
);

  logic              v_q, v_n;
  logic              r_q, r_n;
  logic              d_q, d_n;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [PERM_W-1:0] perm_q;
  logic              clr;
  logic              ld_en;

  assign clr   = flush_all | (flush_asid_en & v_q & (asid_q == flush_asid));
  assign ld_en = load & ~clr;

  always_comb begin
    v_n = v_q;
    r_n = r_q;
    d_n = d_q;
    if (clr) begin
      v_n = 1'b0;
    end else if (load) begin
      v_n = 1'b1;
      r_n = 1'b0;
      d_n = 1'b0;
    end else if (touch) begin
      r_n = 1'b1;
      if (touch_wr) d_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      r_q <= 1'b0;
      d_q <= 1'b0;
    end else begin
      v_q <= v_n;
      r_q <= r_n;
      d_q <= d_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      vpn_q  <= ld_vpn;
      asid_q <= ld_asid;
      ppn_q  <= ld_ppn;
      perm_q <= ld_perm;
    end
  end

  assign lk_match = v_q & (vpn_q == lk_vpn) & (asid_q == lk_asid);
  assign ld_match = v_q & (vpn_q == ld_vpn) & (asid_q == ld_asid);
  assign valid    = v_q;
  assign refb     = r_q;
  assign dirty    = d_q;
  assign vpn      = vpn_q;
  assign asid     = asid_q;
  assign ppn      = ppn_q;
  assign perm     = perm_q;

  AST_FLUSH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !v_q); // R10

  AST_FILL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (v_q && !r_q && !d_q)); // R5

  AST_TOUCH_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !load && !clr) |=> r_q); // R7

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 8,
  parameter int ASID_W  = 3,
  parameter int OFF_W   = 4,
  parameter int LFSR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [VPN_W-1:0]        lk_vpn,
  input  logic [ASID_W-1:0]       lk_asid,
  input  logic [1:0]              lk_acc,
  input  logic [OFF_W-1:0]        lk_off,
  output logic                    lk_hit,
  output logic                    lk_miss,
  output logic                    lk_fault,
  output logic [PPN_W+OFF_W-1:0]  lk_pa,
  input  logic                    fill_valid,
  input  logic [VPN_W-1:0]        fill_vpn,
  input  logic [ASID_W-1:0]       fill_asid,
  input  logic [PPN_W-1:0]        fill_ppn,
  input  logic [2:0]              fill_perm,
  output logic                    wb_valid,
  output logic [VPN_W-1:0]        wb_vpn,
  output logic [ASID_W-1:0]       wb_asid,
  output logic                    wb_ref,
  output logic                    wb_dirty,
  input  logic                    flush_all,
  input  logic                    flush_asid_en,
  input  logic [ASID_W-1:0]       flush_asid
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_valid;
  logic [ENTRIES-1:0] e_ref;
  logic [ENTRIES-1:0] e_dirty;
  logic [ENTRIES-1:0] e_lk_match;
  logic [ENTRIES-1:0] e_ld_match;
  logic [ENTRIES-1:0] e_load;
  logic [ENTRIES-1:0] e_touch;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [PERM_W-1:0]  e_perm [ENTRIES];

  logic [LFSR_W-1:0]  rnd_state;
  logic [IDX_W-1:0]   vidx;
  logic               flush_any;
  logic               fill_go;
  logic               any_match;
  logic [PPN_W-1:0]   sel_ppn;
  logic [PERM_W-1:0]  sel_perm;
  logic               access_ok;
  logic               is_write;
  logic               hit_on_victim;

  assign flush_any = flush_all | flush_asid_en;
  assign fill_go   = fill_valid & ~flush_any;
  assign is_write  = (lk_acc == ACC_WRITE);

  tlb_lfsr #(.W(LFSR_W)) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (1'b1),
    .state (rnd_state)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_vec (e_valid),
    .same_vec  (e_ld_match),
    .rnd       (rnd_state[IDX_W-1:0]),
    .vidx      (vidx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign e_load[g]  = fill_go & (vidx == IDX_W'(g));
    assign e_touch[g] = lk_hit & e_lk_match[g];

    tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) u_entry (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush_all     (flush_all),
      .flush_asid_en (flush_asid_en),
      .flush_asid    (flush_asid),
      .load          (e_load[g]),
      .ld_vpn        (fill_vpn),
      .ld_asid       (fill_asid),
      .ld_ppn        (fill_ppn),
      .ld_perm       (fill_perm),
      .touch         (e_touch[g]),
      .touch_wr      (is_write),
      .lk_vpn        (lk_vpn),
      .lk_asid       (lk_asid),
      .valid         (e_valid[g]),
      .refb          (e_ref[g]),
      .dirty         (e_dirty[g]),
      .vpn           (e_vpn[g]),
      .asid          (e_asid[g]),
      .ppn           (e_ppn[g]),
      .perm          (e_perm[g]),
      .lk_match      (e_lk_match[g]),
      .ld_match      (e_ld_match[g])
    );
  end

  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_ppn  = sel_ppn  | ({PPN_W{e_lk_match[i]}}  & e_ppn[i]);
      sel_perm = sel_perm | ({PERM_W{e_lk_match[i]}} & e_perm[i]);
    end
  end

  assign any_match = |e_lk_match;
  assign access_ok = perm_allows(sel_perm, lk_acc);
  assign lk_hit    = lk_valid & any_match & access_ok;
  assign lk_fault  = lk_valid & any_match & ~access_ok;
  assign lk_miss   = lk_valid & ~any_match;
  assign lk_pa     = lk_hit ? {sel_ppn, lk_off} : '0;

  assign hit_on_victim = lk_hit & e_lk_match[vidx];
  assign wb_vpn        = e_vpn[vidx];
  assign wb_asid       = e_asid[vidx];
  assign wb_ref        = e_ref[vidx] | hit_on_victim;
  assign wb_dirty      = e_dirty[vidx] | (hit_on_victim & is_write);
  assign wb_valid      = fill_go & e_valid[vidx] & (wb_ref | wb_dirty);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault})); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_fault)); // R3

  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(e_lk_match)); // R9

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !(|e_ld_match) && !(&e_valid)) |-> !e_valid[vidx]); // R5

  AST_EVICT_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (fill_valid && !flush_all && !flush_asid_en)); // R12

  AST_EVICT_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_ref || wb_dirty)); // R8

  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (e_valid[$past(vidx)] && e_vpn[$past(vidx)] == $past(fill_vpn))); // R6

endmodule

// File: tb/tb_tlb_assoc.sv
module tb_tlb_assoc;

  localparam int N = 8;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [7:0]  lk_vpn;
  logic [2:0]  lk_asid;
  logic [1:0]  lk_acc;
  logic [3:0]  lk_off;
  logic        lk_hit, lk_miss, lk_fault;
  logic [11:0] lk_pa;
  logic        fill_valid;
  logic [7:0]  fill_vpn;
  logic [2:0]  fill_asid;
  logic [7:0]  fill_ppn;
  logic [2:0]  fill_perm;
  logic        wb_valid;
  logic [7:0]  wb_vpn;
  logic [2:0]  wb_asid;
  logic        wb_ref, wb_dirty;
  logic        flush_all, flush_asid_en;
  logic [2:0]  flush_asid;

  int n_chk = 0;
  int n_fail = 0;

  bit         m_v     [N];
  logic [7:0] m_vpn   [N];
  logic [2:0] m_asid  [N];
  logic [7:0] m_ppn   [N];
  logic [2:0] m_perm  [N];
  bit         m_ref   [N];
  bit         m_dirty [N];

  logic [7:0] p_vpn;
  logic [2:0] p_asid;
  logic [7:0] p_ppn;
  logic [2:0] p_perm;
  bit         c_wbv, c_ref, c_dirty;
  logic [7:0] c_vpn;
  logic [2:0] c_asid;

  tlb_assoc dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc), .lk_off(lk_off),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pa(lk_pa),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_asid(wb_asid), .wb_ref(wb_ref), .wb_dirty(wb_dirty),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find(input logic [7:0] v, input logic [2:0] a);
    for (int j = 0; j < N; j++)
      if (m_v[j] && m_vpn[j] == v && m_asid[j] == a) return j;
    return -1;
  endfunction

  function automatic int free_slot();
    for (int j = 0; j < N; j++)
      if (!m_v[j]) return j;
    return -1;
  endfunction

  function automatic bit pok(input logic [2:0] perm, input logic [1:0] acc);
    if (acc == 2'd0) return perm[0];
    if (acc == 2'd1) return perm[1];
    if (acc == 2'd2) return perm[2];
    return 1'b0;
  endfunction

  task automatic idle();
    lk_valid = 0; lk_vpn = 0; lk_asid = 0; lk_acc = 0; lk_off = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_ppn = 0; fill_perm = 0;
    flush_all = 0; flush_asid_en = 0; flush_asid = 0;
  endtask

  task automatic install(input int s, input logic [7:0] v, input logic [2:0] a,
                         input logic [7:0] p, input logic [2:0] pm);
    m_v[s] = 1; m_vpn[s] = v; m_asid[s] = a; m_ppn[s] = p; m_perm[s] = pm;
    m_ref[s] = 0; m_dirty[s] = 0;
  endtask

  task automatic op(input bit lv, input logic [7:0] lvpn, input logic [2:0] lasid,
                    input logic [1:0] lacc, input logic [3:0] loff,
                    input bit fv, input logic [7:0] fvpn, input logic [2:0] fasid,
                    input logic [7:0] fppn, input logic [2:0] fperm,
                    input bit fa, input bit fe, input logic [2:0] fas,
                    input string req, output bit unk);
    int li, fx, fs;
    bit eh, ef, go, hov, er, ed;
    unk = 0;
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvpn; lk_asid = lasid; lk_acc = lacc; lk_off = loff;
    fill_valid = fv; fill_vpn = fvpn; fill_asid = fasid; fill_ppn = fppn; fill_perm = fperm;
    flush_all = fa; flush_asid_en = fe; flush_asid = fas;
    #2;
    li = lv ? find(lvpn, lasid) : -1;
    eh = 0; ef = 0;
    if (li >= 0) begin
      eh = pok(m_perm[li], lacc);
      ef = !eh;
    end
    chk(req, "hit", lk_hit, eh);
    chk(req, "miss", lk_miss, lv && li < 0);
    chk(req, "fault", lk_fault, ef);
    if (eh) chk(req, "pa", lk_pa, {m_ppn[li], loff});
    go = fv && !fa && !fe;
    fx = go ? find(fvpn, fasid) : -1;
    fs = free_slot();
    if (go && fx >= 0) begin
      hov = eh && li == fx;
      er  = m_ref[fx] | hov;
      ed  = m_dirty[fx] | (hov && lacc == 2'd1);
      chk(req, "wb_valid", wb_valid, er | ed);
      if (er | ed) begin
        chk(req, "wb_vpn", wb_vpn, m_vpn[fx]);
        chk(req, "wb_asid", wb_asid, m_asid[fx]);
        chk(req, "wb_ref", wb_ref, er);
        chk(req, "wb_dirty", wb_dirty, ed);
      end
    end else if (go && fs < 0) begin
      unk = 1;
      c_wbv = wb_valid; c_vpn = wb_vpn; c_asid = wb_asid; c_ref = wb_ref; c_dirty = wb_dirty;
    end else begin
      chk(req, "wb_valid idle", wb_valid, 0);
    end
    @(posedge clk);
    #1;
    idle();
    if (eh) begin
      m_ref[li] = 1;
      if (lacc == 2'd1) m_dirty[li] = 1;
    end
    for (int j = 0; j < N; j++) begin
      if (fa) m_v[j] = 0;
      if (fe && m_asid[j] == fas) m_v[j] = 0;
    end
    if (go) begin
      if (fx >= 0) install(fx, fvpn, fasid, fppn, fperm);
      else if (fs >= 0) install(fs, fvpn, fasid, fppn, fperm);
      else begin
        p_vpn = fvpn; p_asid = fasid; p_ppn = fppn; p_perm = fperm;
      end
    end
  endtask

  task automatic resolve();
    int gone, ng;
    bit present, hitj, er, ed;
    gone = -1; ng = 0;
    for (int j = 0; j < N; j++) begin
      if (m_v[j]) begin
        @(negedge clk);
        lk_valid = 1; lk_vpn = m_vpn[j]; lk_asid = m_asid[j]; lk_acc = 2'd0; lk_off = 0;
        #2;
        present = lk_hit | lk_fault;
        hitj    = lk_hit;
        @(posedge clk);
        #1;
        idle();
        if (hitj) m_ref[j] = 1;
        if (!present) begin
          gone = j;
          ng++;
        end
      end
    end
    chk("R6", "slots displaced", ng, 1);
    if (ng == 1) begin
      er = m_ref[gone]; ed = m_dirty[gone];
      chk("R8", "wb_valid", c_wbv, er | ed);
      if (er | ed) begin
        chk("R8", "wb_vpn", c_vpn, m_vpn[gone]);
        chk("R8", "wb_asid", c_asid, m_asid[gone]);
        chk("R8", "wb_ref", c_ref, er);
        chk("R8", "wb_dirty", c_dirty, ed);
      end
      install(gone, p_vpn, p_asid, p_ppn, p_perm);
    end
  endtask

  task automatic do_fill(input logic [7:0] v, input logic [2:0] a, input logic [7:0] p,
                         input logic [2:0] pm, input string req);
    bit u;
    op(0, 0, 0, 0, 0, 1, v, a, p, pm, 0, 0, 0, req, u);
    if (u) resolve();
  endtask

  task automatic do_look(input logic [7:0] v, input logic [2:0] a, input logic [1:0] acc,
                         input string req);
    bit u;
    op(1, v, a, acc, v[3:0] ^ {1'b0, a}, 0, 0, 0, 0, 0, 0, 0, 0, req, u);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired before the run completed");
    summary();
    $finish;
  end

  initial begin
    bit u;
    logic [7:0] sv_vpn [N];
    logic [2:0] sv_asid [N];
    bit         sv_v [N];
    idle();
    for (int j = 0; j < N; j++) begin
      m_v[j] = 0; m_ref[j] = 0; m_dirty[j] = 0;
      m_vpn[j] = 0; m_asid[j] = 0; m_ppn[j] = 0; m_perm[j] = 0;
    end
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: nothing translates after reset
    for (int k = 0; k < 6; k++) do_look(8'(k * 37), 3'(k), 2'(k % 3), "R1");
    chk("R1", "wb_valid after reset", wb_valid, 0);

    // R5: fills into free slots never evict
    for (int i = 0; i < N; i++)
      do_fill(8'(8'h10 + i * 5), 3'(i % 3), 8'(8'hC0 ^ (i * 7)), 3'(i), "R5");

    // R2 R3 R4 R7: sweep every page, four tags, three access kinds
    for (int v = 0; v < 256; v++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 3; c++) begin
          int f;
          f = find(8'(v), 3'(a));
          if (f < 0) do_look(8'(v), 3'(a), 2'(c), "R3");
          else if (pok(m_perm[f], 2'(c))) do_look(8'(v), 3'(a), 2'(c), "R2");
          else do_look(8'(v), 3'(a), 2'(c), "R4");
        end
    do_look(8'h1F, 3'd0, 2'd3, "R4");

    // R9: refill a present page that was read and written
    do_fill(8'h1F, 3'd0, 8'h5A, 3'b111, "R9");
    do_look(8'h1F, 3'd0, 2'd0, "R9");
    // R7: flags observed through successive refills
    do_fill(8'h1F, 3'd0, 8'h5B, 3'b111, "R7");
    do_fill(8'h1F, 3'd0, 8'h5C, 3'b111, "R7");
    do_look(8'h1F, 3'd0, 2'd1, "R7");
    do_fill(8'h1F, 3'd0, 8'h5D, 3'b000, "R7");
    do_look(8'h1F, 3'd0, 2'd0, "R7");
    do_look(8'h1F, 3'd0, 2'd2, "R7");
    do_fill(8'h1F, 3'd0, 8'h5E, 3'b101, "R7");

    // R6: random replacement in a full buffer
    for (int k = 0; k < 20; k++) begin
      do_fill(8'(8'h80 + k), 3'(k % 4), 8'(k * 11), 3'((k % 7) + 1), "R6");
      if (k % 3 == 0) do_look(8'(8'h80 + k), 3'(k % 4), 2'(k % 3), "R7");
    end

    // R13: lookup hit on the slot displaced in the same cycle
    do_fill(8'h55, 3'd1, 8'h33, 3'b111, "R13");
    do_fill(8'h55, 3'd1, 8'h34, 3'b111, "R13");
    op(1, 8'h55, 3'd1, 2'd1, 4'h9, 1, 8'h55, 3'd1, 8'h35, 3'b111, 0, 0, 0, "R13", u);
    do_look(8'h55, 3'd1, 2'd0, "R13");

    // R11: tagged flush
    do_fill(8'h60, 3'd2, 8'h01, 3'b001, "R11");
    do_fill(8'h61, 3'd3, 8'h02, 3'b001, "R11");
    for (int j = 0; j < N; j++) begin
      sv_v[j] = m_v[j]; sv_vpn[j] = m_vpn[j]; sv_asid[j] = m_asid[j];
    end
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd2, "R11", u);
    for (int j = 0; j < N; j++)
      if (sv_v[j]) do_look(sv_vpn[j], sv_asid[j], 2'd0, "R11");

    // R12: fill dropped when a flush arrives in the same cycle
    op(0, 0, 0, 0, 0, 1, 8'hEE, 3'd1, 8'h77, 3'b111, 1, 0, 0, "R12", u);
    do_look(8'hEE, 3'd1, 2'd0, "R12");
    do_fill(8'hE0, 3'd0, 8'h40, 3'b111, "R12");
    op(0, 0, 0, 0, 0, 1, 8'hE1, 3'd2, 8'h41, 3'b111, 0, 1, 3'd5, "R12", u);
    do_look(8'hE1, 3'd2, 2'd0, "R12");
    do_look(8'hE0, 3'd0, 2'd0, "R12");

    // R10: global flush
    do_fill(8'hA0, 3'd4, 8'h90, 3'b011, "R10");
    do_fill(8'hA1, 3'd5, 8'h91, 3'b011, "R10");
    for (int j = 0; j < N; j++) begin
      sv_v[j] = m_v[j]; sv_vpn[j] = m_vpn[j]; sv_asid[j] = m_asid[j];
    end
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10", u);
    for (int j = 0; j < N; j++)
      if (sv_v[j]) do_look(sv_vpn[j], sv_asid[j], 2'd0, "R10");
    do_fill(8'hB0, 3'd0, 8'h12, 3'b001, "R5");

    summary();
    $finish;
  end

endmodule